// File: doc/BRIEF.md
# Pruned CIC Decimation Filter

This block reduces the sample rate of a 16-bit signed stream by a fixed factor of 1000. It uses a five-stage cascaded integrator-comb structure. Five integrators run at the input rate and wrap freely in two's-complement arithmetic. A decimation counter picks one integrator result out of every 1000 accepted samples. Five single-delay comb stages then process that result at the output rate. The top 16 bits of the last comb form the output sample. The internal datapath is 66 bits wide, which is the input width plus the worst-case gain of the filter.

A build-time parameter selects how the datapath is pruned:
- **Per-stage pruning:** each stage drops a computed number of low-order bits at its input. The number dropped is chosen so that the rounding error of any one stage stays well under one output LSB.
- **Output-only pruning:** every stage keeps the full width, and bits are dropped only when the top 16 bits are taken at the output.

Upstream logic offers a sample with a valid strobe. Downstream logic takes each decimated result on a one-cycle valid pulse. A synchronous reset clears the block.

Top module: `cic_decim`

## Requirements
- R1: A synchronous active-high reset clears all filter and counter state. Afterwards `out_valid` is low and `out_data` is zero, and no `out_valid` pulse occurs until 1000 samples have been accepted since the reset.
- R2: Only cycles with `in_valid` high advance the filter. The value of `in_data` in other cycles has no effect, and no output pulse occurs while no samples arrive.
- R3: `out_valid` is a pulse one cycle long, issued once per 1000 accepted samples. It is high in the cycle after the fifth clock edge following the edge that accepted the 1000th sample of the group.
- R4: `out_data` holds its value in every cycle in which `out_valid` is low.
- R5: With output-only pruning, output number m (counted from 0 after reset) is exact. It equals floor(Y/2^50), where Y is the exact result of five cumulative sums of the accepted samples, sampled once per 1000 samples and passed through five first differences. The sums cover samples 0 to (m+1)·1000−5. The four most recent samples reach the next output instead.
- R6: With per-stage pruning, every output lies within ±2 LSB of the exact value defined in R5.
- R7: For a constant input x held long enough to fill the filter, the output settles to floor(x·1000^5/2^50). For example, 32767 gives 29102 and −32768 gives −29104. Per-stage pruning may differ by up to ±2 LSB.
- R8: Integrator registers wrap modulo 2^66 without saturating. Correct outputs continue after 20000 full-scale samples, which is long after the integrators have wrapped.
- R9: No output exceeds the full-scale magnitude 32768·1000^5/2^50 by more than 3 LSB. In practice every output lies within ±29106.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a decimated result |
| out_data | output | 16 | Signed decimated sample, held between pulses |

## Verification
The bench holds full-scale positive and negative levels for tens of thousands of samples.
- A design that saturated its integrators, or kept them too narrow, would drift away from the settled DC value once they wrap.

The bench also runs random samples with gaps in `in_valid`, and compares both pruning builds against an exact wide-integer model.
- A design that advanced on idle cycles, or shifted the decimation phase by a sample, would disagree with the model.
- A design with too much per-stage truncation would leave the ±2 LSB band.

Finally, the bench resets the block partway through a group and then feeds exactly 999 samples.
- A counter that survived the reset would pulse early.
- An off-by-one in the strobe pipeline would move the pulse away from its fixed position after the 1000th sample.

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W       = 16,
  parameter int OUT_W      = 16,
  parameter int N          = 5,
  parameter int R          = 1000,
  parameter bit PRUNE_EACH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int RB = $clog2(R);
  localparam int G  = N * RB;
  localparam int W  = IN_W + G;
  localparam int CW = (RB < 1) ? 1 : RB;

  // low bits dropped at the input of stage s (0..N-1 integrators, N..2N-1 combs)
  function automatic int drop_bits(input int s);
    int d;
    if (!PRUNE_EACH || s == 0) return 0;
    d = (s < N) ? G - (N - s) * RB - s - 3 : G - (2 * N - s) - 3;
    if (d < 0) d = 0;
    if (d > W - OUT_W) d = W - OUT_W;
    return d;
  endfunction

  logic [N:0][W-1:0] ichain;
  logic [N:0][W-1:0] cchain;
  logic [CW-1:0]     cnt;
  logic [N:0]        stb;
  logic              last;

  assign last      = (cnt == CW'(R - 1));
  assign ichain[0] = {{G{in_data[IN_W-1]}}, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      stb <= '0;
    end else begin
      stb <= {stb[N-1:0], in_valid & last};
      if (in_valid) cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_integ
    localparam logic [W-1:0] KEEP = {W{1'b1}} << drop_bits(i);
    logic [W-1:0] acc;
    always_ff @(posedge clk) begin
      if (rst)           acc <= '0;
      else if (in_valid) acc <= acc + (ichain[i] & KEEP);
    end
    assign ichain[i+1] = acc;
  end

  assign cchain[0] = ichain[N];

  for (genvar k = 0; k < N; k++) begin : g_comb
    localparam logic [W-1:0] KEEP = {W{1'b1}} << drop_bits(N + k);
    logic [W-1:0] held, diff, cur;
    assign cur = cchain[k] & KEEP;
    always_ff @(posedge clk) begin
      if (rst) begin
        held <= '0;
        diff <= '0;
      end else if (stb[k]) begin
        held <= cur;
        diff <= cur - held;
      end
    end
    assign cchain[k+1] = diff;
  end

  logic unused_low;
  assign unused_low = ^cchain[N][W-OUT_W-1:0];

  assign out_valid = stb[N];
  assign out_data  = cchain[N][W-1 -: OUT_W];
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int N     = 5,
  parameter int R     = 1000
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int G = N * $clog2(R);

  function automatic longint peak_mag();
    logic [127:0] p;
    p = 128'd1;
    for (int i = 0; i < N; i++) p = p * 128'(R);
    p = (p << (IN_W - 1)) >> G;
    return longint'(p) + 64'sd3;
  endfunction

  localparam longint LIM = peak_mag();

  int seen;
  always_ff @(posedge clk) begin
    if (rst)                      seen <= 0;
    else if (in_valid && seen < R) seen <= seen + 1;
  end

  // R1: a pulse only once a full group has been accepted since reset
  assert_first_group_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen == R);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  assert_out_bound_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'($signed(out_data)) <= LIM) &&
                  (longint'($signed(out_data)) >= -LIM));
endmodule

bind cic_decim cic_decim_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .N(N), .R(R)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_cic_decim.sv
module sim_cic_decim;
  localparam int R = 1000;
  localparam int G = 50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        ov_a, ov_b;
  logic [15:0] od_a, od_b;

  cic_decim u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
                .out_valid(ov_a), .out_data(od_a));
  cic_decim #(.PRUNE_EACH(1'b0)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid),
                .in_data(in_data), .out_valid(ov_b), .out_data(od_b));

  int checks = 0, fails = 0, outs = 0, age = 0, nacc = 0;
  bit pend = 0, hold_bad = 0, done = 0;
  logic signed [127:0] ig [5];
  logic signed [127:0] cd [5];
  logic signed [15:0]  hist [4];
  longint exp_v, last_a, last_b;
  logic [15:0] held_a, held_b;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint dc_level(input longint x);
    logic signed [127:0] p;
    p = 128'(x);
    for (int i = 0; i < 5; i++) p = p * 128'sd1000;
    return longint'(p >>> G);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) begin ig[i] = '0; cd[i] = '0; end
    for (int i = 0; i < 4; i++) hist[i] = '0;
    nacc = 0;
    pend = 0;
  endtask

  // exact wide model: four-sample integrator lag, then five sums, decimate, five differences
  task automatic model_take(input logic signed [15:0] x);
    logic signed [127:0] v, t;
    v = 128'(hist[3]);
    for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    ig[0] = ig[0] + v;
    for (int i = 1; i < 5; i++) ig[i] = ig[i] + ig[i-1];
    nacc++;
    if (nacc % R == 0) begin
      v = ig[4];
      for (int k = 0; k < 5; k++) begin
        t = v - cd[k];
        cd[k] = v;
        v = t;
      end
      exp_v = longint'(v >>> G);
      pend = 1;
      age = 0;
    end
  endtask

  task automatic observe();
    if (pend) age++;
    if (ov_a || ov_b) begin
      outs++;
      check(ov_a && ov_b && pend && age == 6, "R3", longint'(age), 64'd6);
      check(!hold_bad, "R4", longint'(hold_bad), 64'd0);
      last_a = longint'($signed(od_a));
      last_b = longint'($signed(od_b));
      check(last_b == exp_v, "R5", last_b, exp_v);
      check(last_a >= exp_v - 2 && last_a <= exp_v + 2, "R6", last_a, exp_v);
      check(last_a <= 29106 && last_a >= -29106 && last_b <= 29106 && last_b >= -29106,
            "R9", last_a, last_b);
      pend = 0;
      hold_bad = 0;
      held_a = od_a;
      held_b = od_b;
    end else begin
      if (od_a != held_a || od_b != held_b) hold_bad = 1;
      if (pend && age > 6) begin
        check(1'b0, "R3", longint'(age), 64'd6);
        pend = 0;
      end
    end
  endtask

  task automatic step(input bit v, input logic [15:0] d);
    @(negedge clk);
    observe();
    in_valid = v;
    in_data  = d;
    if (v) model_take(d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!ov_a && !ov_b && od_a == 0 && od_b == 0, "R1",
          longint'({ov_a, ov_b, od_a, od_b}), 64'd0);
    held_a = '0;
    held_b = '0;
    hold_bad = 0;
  endtask

  task automatic run_dc(input int n, input logic [15:0] x);
    int target;
    target = outs + n;
    while (outs < target) step(1'b1, x);
  endtask

  task automatic run_rand(input int n);
    int target;
    logic [15:0] d;
    target = outs + n;
    while (outs < target) begin
      case ($urandom % 4)
        0:       d = 16'($urandom);
        1:       d = 16'h7fff;
        2:       d = 16'h8000;
        default: d = 16'($urandom % 64) - 16'd32;
      endcase
      step(($urandom % 10) < 7, d);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int idle_pulses, o0;
    void'($urandom(32'd7321));
    do_reset();

    run_dc(12, 16'h7fff);
    check(last_b == dc_level(32767), "R7", last_b, dc_level(32767));
    check(last_a >= dc_level(32767) - 2 && last_a <= dc_level(32767) + 2, "R7",
          last_a, dc_level(32767));

    // integrators have wrapped many times by now
    run_dc(8, 16'h7fff);
    check(last_b == dc_level(32767), "R8", last_b, dc_level(32767));

    run_dc(8, 16'h8000);
    check(last_b == dc_level(-32768), "R7", last_b, dc_level(-32768));
    check(last_a >= dc_level(-32768) - 2 && last_a <= dc_level(-32768) + 2, "R7",
          last_a, dc_level(-32768));

    idle_pulses = 0;
    repeat (2000) begin
      step(1'b0, 16'($urandom));
      if (ov_a || ov_b) idle_pulses++;
    end
    check(idle_pulses == 0, "R2", longint'(idle_pulses), 64'd0);
    run_dc(2, 16'h8000);
    check(last_b == dc_level(-32768), "R2", last_b, dc_level(-32768));

    run_rand(40);

    repeat (500) step(1'b1, 16'($urandom));
    do_reset();
    o0 = outs;
    repeat (R - 1) step(1'b1, 16'd12000);
    repeat (8) step(1'b0, 16'd0);
    check(outs == o0, "R1", longint'(outs - o0), 64'd0);
    run_dc(6, 16'd12000);
    check(last_b == dc_level(12000), "R7", last_b, dc_level(12000));

    repeat (10) step(1'b0, 16'd0);
    check(!pend, "R3", longint'(pend), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule